// File: doc/BRIEF.md
# Split-Phase Fault-Avoiding Link Transceiver

This block moves a LINK_W-bit flit from one router port to the next across a link in which some wires are permanently broken. A static configuration vector marks every broken wire. In split mode, the transmitter uses only healthy wires. It sends the lower half of the flit while the clock is high and the upper half while the clock is low. The receiver pulls each half off the same healthy wires and rebuilds the whole flit at the following rising edge, ready for the input buffer. A flit therefore needs one clock cycle to cross the link, in split mode and in direct mode alike.

In direct mode the map is not used, and the link is a plain registered LINK_W-bit path. Valid and ready use their own control wires and are never split. When split mode is chosen with more broken wires than half the link width, there are too few healthy wires to carry a half-flit. The block then raises a configuration error and shuts the link. Finding the broken wires and storing the received flits are handled elsewhere.

Top module: `split_link_xcvr`

## Requirements
- R1: While reset is asserted and right after it is released, `rx_valid` is 0 and `link_out` is all zeros.
- R2: In split mode, with at most LINK_W/2 bits set in `fault_map`, every flit accepted at the transmitter comes out on `rx_flit` unchanged, whatever values the broken wires carry at the receiver.
- R3: A flit accepted at rising edge k (`tx_valid` and `tx_ready` both high) shows `rx_valid` = 1 during the cycle after edge k+1, in both modes. `rx_valid` is never high unless a flit was accepted two edges earlier.
- R4: In direct mode (`split_en` = 0) the map has no effect. `cfg_err` stays 0, `link_out` carries the whole held flit in both clock phases, and `rx_flit` equals `link_in` as sampled at the rising edge.
- R5: In split mode with a legal map, the transmitter drives 0 on every wire whose `fault_map` bit is 1, in both clock phases.
- R6: In split mode, healthy wires are taken in ascending wire index. Flit bit i of the lower half (bits 0 to LINK_W/2-1) goes on the i-th healthy wire during the high phase. Flit bit LINK_W/2+i goes on the same wire during the low phase. Healthy wires beyond the first LINK_W/2 carry 0.
- R7: When `split_en` = 1 and more than LINK_W/2 bits of `fault_map` are set, `cfg_err` = 1, `tx_ready` = 0, `link_out` is all zeros and `rx_valid` stays 0.
- R8: `tx_ready` equals `rx_ready` whenever `cfg_err` is 0. A flit offered while `rx_ready` is 0 is not accepted and never arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both of its phases carry data |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_en | input | 1 | 1 = split mode over healthy wires, 0 = direct mode |
| fault_map | input | LINK_W | Bit w set means wire w is broken |
| tx_valid | input | 1 | Flit offered for sending |
| tx_flit | input | LINK_W | Flit to send |
| tx_ready | output | 1 | Transmitter accepts the flit at this edge |
| link_out | output | LINK_W | Wires driven onto the link |
| link_in | input | LINK_W | Wires as seen at the receiving end |
| rx_ready | input | 1 | Receiving buffer has room |
| rx_valid | output | 1 | Rebuilt flit is valid |
| rx_flit | output | LINK_W | Rebuilt flit |
| cfg_err | output | 1 | Split mode requested with too many broken wires |

## Verification
The bench corrupts the broken wires between `link_out` and `link_in` with fresh random values every cycle. A design that read a broken wire, or placed half-bits in a different order on the two ends, would deliver a damaged flit. It checks both the high and the low phase of the wires against an independently computed spread. This catches a swapped half, a wrong wire order, or a live drive on a broken wire. The corner cases cover maps with no broken wires, with exactly half broken, and with all the broken wires crowded at either end of the bus. Maps one wire past the limit check that the link shuts down instead of sending scrambled data. A design that added a cycle in split mode, or lost the held lower half, would fail the fixed-latency arrival checks.

// File: rtl/split_link_pkg.sv
package split_link_pkg;

    // Operating mode of the link, derived from configuration.
    typedef enum logic [1:0] {
        MODE_DIRECT = 2'd0,
        MODE_SPLIT  = 2'd1,
        MODE_OFF    = 2'd2
    } lane_mode_e;

endpackage

// File: rtl/split_link_scatter.sv
// Places a half-width word on the healthy wires, lowest healthy wire first.
module split_link_scatter #(
    parameter int LINK_W = 16
) (
    input  logic [LINK_W-1:0]   lane_map,
    input  logic [LINK_W/2-1:0] half_in,
    output logic [LINK_W-1:0]   wires_out
);
    localparam int HALF_W = LINK_W / 2;
    localparam int CNT_W  = $clog2(HALF_W) + 1;

    logic [CNT_W-1:0] used;

    always_comb begin
        used      = '0;
        wires_out = '0;
        for (int w = 0; w < LINK_W; w++) begin
            if (!lane_map[w] && (used < CNT_W'(HALF_W))) begin
                wires_out[w] = half_in[used[CNT_W-2:0]];
                used         = used + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/split_link_gather.sv
// Collects a half-width word from the healthy wires, lowest healthy wire first.
module split_link_gather #(
    parameter int LINK_W = 16
) (
    input  logic [LINK_W-1:0]   lane_map,
    input  logic [LINK_W-1:0]   wires_in,
    output logic [LINK_W/2-1:0] half_out
);
    localparam int HALF_W = LINK_W / 2;
    localparam int CNT_W  = $clog2(HALF_W) + 1;

    logic [CNT_W-1:0] used;

    always_comb begin
        used     = '0;
        half_out = '0;
        for (int w = 0; w < LINK_W; w++) begin
            if (!lane_map[w] && (used < CNT_W'(HALF_W))) begin
                half_out[used[CNT_W-2:0]] = wires_in[w];
                used                      = used + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/split_link_xcvr.sv
// Link transceiver: in split mode a flit crosses the link in two clock phases
// over healthy wires only; in direct mode it crosses as one full-width word.
module split_link_xcvr
    import split_link_pkg::*;
#(
    parameter int LINK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              split_en,
    input  logic [LINK_W-1:0] fault_map,
    input  logic              tx_valid,
    input  logic [LINK_W-1:0] tx_flit,
    output logic              tx_ready,
    output logic [LINK_W-1:0] link_out,
    input  logic [LINK_W-1:0] link_in,
    input  logic              rx_ready,
    output logic              rx_valid,
    output logic [LINK_W-1:0] rx_flit,
    output logic              cfg_err
);
    localparam int HALF_W = LINK_W / 2;

    // Rising-edge state. The link is driven as pos ^ neg, so each clock edge
    // changes the wires through a register and no data path muxes on clk.
    typedef struct packed {
        logic [LINK_W-1:0] flit;    // flit being sent this cycle
        logic              vld;     // control wire: flit sent this cycle
        logic [LINK_W-1:0] pos;     // rising-edge half of the wire encoding
        logic [LINK_W-1:0] rx_flit;
        logic              rx_vld;
    } rise_t;

    rise_t st_d, st_q;

    // Falling-edge state.
    logic [LINK_W-1:0] neg_d, neg_q;    // falling-edge half of the encoding
    logic [HALF_W-1:0] rxlo_d, rxlo_q;  // first half captured at end of high phase

    lane_mode_e        mode;
    logic              over_limit;
    logic              accept;
    logic [LINK_W-1:0] flit_nxt;
    logic [LINK_W-1:0] first_wires, second_wires;
    logic [LINK_W-1:0] first_word, second_word;
    logic [HALF_W-1:0] rx_half;

    assign over_limit = ($countones(fault_map) > HALF_W);
    assign cfg_err    = split_en && over_limit;
    assign tx_ready   = rx_ready && !cfg_err;
    assign accept     = tx_valid && tx_ready;
    assign flit_nxt   = accept ? tx_flit : st_q.flit;

    always_comb begin
        if (cfg_err)       mode = MODE_OFF;
        else if (split_en) mode = MODE_SPLIT;
        else               mode = MODE_DIRECT;
    end

    // Lower half of the incoming flit, driven during the high phase.
    split_link_scatter #(.LINK_W(LINK_W)) u_scatter_first (
        .lane_map (fault_map),
        .half_in  (flit_nxt[HALF_W-1:0]),
        .wires_out(first_wires)
    );

    // Upper half of the held flit, driven during the low phase.
    split_link_scatter #(.LINK_W(LINK_W)) u_scatter_second (
        .lane_map (fault_map),
        .half_in  (st_q.flit[LINK_W-1:HALF_W]),
        .wires_out(second_wires)
    );

    split_link_gather #(.LINK_W(LINK_W)) u_gather (
        .lane_map(fault_map),
        .wires_in(link_in),
        .half_out(rx_half)
    );

    always_comb begin
        st_d = st_q;

        unique case (mode)
            MODE_SPLIT: begin
                first_word  = first_wires;
                second_word = second_wires;
            end
            MODE_DIRECT: begin
                first_word  = flit_nxt;
                second_word = st_q.flit;
            end
            default: begin
                first_word  = '0;
                second_word = '0;
            end
        endcase

        // transmit side
        st_d.flit = flit_nxt;
        st_d.vld  = accept;
        st_d.pos  = first_word ^ neg_q;
        neg_d     = second_word ^ st_q.pos;

        // receive side
        rxlo_d      = rx_half;
        st_d.rx_vld = st_q.vld && (mode != MODE_OFF);
        unique case (mode)
            MODE_SPLIT:  st_d.rx_flit = {rx_half, rxlo_q};
            MODE_DIRECT: st_d.rx_flit = link_in;
            default:     st_d.rx_flit = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_q  <= '0;
            rxlo_q <= '0;
        end else begin
            neg_q  <= neg_d;
            rxlo_q <= rxlo_d;
        end
    end

    assign link_out = st_q.pos ^ neg_q;
    assign rx_valid = st_q.rx_vld;
    assign rx_flit  = st_q.rx_flit;

endmodule

// File: rtl/split_link_checker.sv
module split_link_checker #(
    parameter int LINK_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              split_en,
    input logic [LINK_W-1:0] fault_map,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [LINK_W-1:0] link_out,
    input logic              rx_valid,
    input logic              cfg_err
);
    // R7: an illegal split configuration blocks the transmitter
    p_err_blocks_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !tx_ready);

    // R7: a shut link never delivers a flit
    p_err_no_delivery_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && $stable(cfg_err)) |-> !rx_valid);

    // R5: broken wires stay low while the configuration is steady
    p_quiet_faulty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (split_en && !cfg_err && $stable(fault_map) && $stable(split_en))
        |-> ((link_out & fault_map) == '0));

    // R3: an accepted flit arrives after exactly two edges
    p_arrival_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |-> ##2 rx_valid);

    // R3: nothing arrives without a send two edges earlier
    p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(tx_valid && tx_ready, 2));

endmodule

bind split_link_xcvr split_link_checker #(.LINK_W(LINK_W)) u_split_link_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .split_en (split_en),
    .fault_map(fault_map),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .link_out (link_out),
    .rx_valid (rx_valid),
    .cfg_err  (cfg_err)
);

// File: tb/test_split_link_xcvr.sv
module test_split_link_xcvr;
    localparam int W = 16;
    localparam int H = W / 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         split_en = 1'b0;
    logic [W-1:0] fault_map = '0;
    logic         tx_valid = 1'b0;
    logic [W-1:0] tx_flit = '0;
    logic         tx_ready;
    logic [W-1:0] link_out;
    logic [W-1:0] link_in;
    logic         rx_ready = 1'b1;
    logic         rx_valid;
    logic [W-1:0] rx_flit;
    logic         cfg_err;
    logic [W-1:0] stuck = '0;

    int total = 0;
    int bad   = 0;

    logic         exp_v = 1'b0;
    logic [W-1:0] exp_f = '0;
    logic [W-1:0] cur   = '0;

    always #5 clk = ~clk;

    // broken wires show garbage at the receiving end in split mode
    assign link_in = (link_out & ~(split_en ? fault_map : '0)) |
                     (stuck & (split_en ? fault_map : '0));

    split_link_xcvr #(.LINK_W(W)) i_split_link_xcvr (
        .clk(clk), .rst_n(rst_n), .split_en(split_en), .fault_map(fault_map),
        .tx_valid(tx_valid), .tx_flit(tx_flit), .tx_ready(tx_ready),
        .link_out(link_out), .link_in(link_in), .rx_ready(rx_ready),
        .rx_valid(rx_valid), .rx_flit(rx_flit), .cfg_err(cfg_err)
    );

    function automatic int ones(input logic [W-1:0] m);
        int n = 0;
        for (int i = 0; i < W; i++) if (m[i]) n++;
        return n;
    endfunction

    function automatic logic [W-1:0] spread(input logic [W-1:0] m, input logic [H-1:0] h);
        logic [W-1:0] r = '0;
        int k = 0;
        for (int w = 0; w < W; w++) begin
            if (!m[w] && k < H) begin
                r[w] = h[k];
                k++;
            end
        end
        return r;
    endfunction

    function automatic logic [W-1:0] rand_map(input int k);
        logic [W-1:0] m = '0;
        while (ones(m) < k) m[$urandom_range(W-1, 0)] = 1'b1;
        return m;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [W-1:0] f, input logic rr);
        logic         err_e;
        logic         acc;
        logic [W-1:0] w1, w2;
        tx_valid = v;
        tx_flit  = f;
        rx_ready = rr;
        stuck    = W'($urandom);
        @(posedge clk);
        #2;
        err_e = split_en && (ones(fault_map) > H);
        acc   = v && rr && !err_e;
        if (acc) cur = f;
        chk(rx_valid == exp_v, "R3 rx_valid", W'(rx_valid), W'(exp_v));
        if (exp_v) chk(rx_flit == exp_f, split_en ? "R2 rx_flit" : "R4 rx_flit", rx_flit, exp_f);
        chk(tx_ready == (rr && !err_e), "R8 tx_ready", W'(tx_ready), W'(rr && !err_e));
        chk(cfg_err == err_e, "R7 cfg_err", W'(cfg_err), W'(err_e));
        exp_v = acc;
        exp_f = f;
        w1 = err_e ? '0 : (split_en ? spread(fault_map, cur[H-1:0]) : cur);
        w2 = err_e ? '0 : (split_en ? spread(fault_map, cur[W-1:H]) : cur);
        chk(link_out == w1, split_en ? "R6 high phase" : "R4 high phase", link_out, w1);
        @(negedge clk);
        #2;
        chk(link_out == w2, split_en ? "R6 low phase" : "R4 low phase", link_out, w2);
        if (split_en && !err_e)
            chk((link_out & fault_map) == '0, "R5 quiet wires", link_out & fault_map, '0);
    endtask

    task automatic set_cfg(input logic s, input logic [W-1:0] m);
        step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b1);
        split_en  = s;
        fault_map = m;
        step(1'b0, '0, 1'b1);
    endtask

    task automatic burst(input int n);
        for (int i = 0; i < n; i++)
            step($urandom_range(3, 0) != 0, W'($urandom), $urandom_range(7, 0) != 0);
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #2;
        chk(rx_valid == 1'b0, "R1 rx_valid in reset", W'(rx_valid), '0);
        chk(link_out == '0, "R1 link in reset", link_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(rx_valid == 1'b0, "R1 rx_valid after reset", W'(rx_valid), '0);
        chk(link_out == '0, "R1 link after reset", link_out, '0);

        // direct mode with a map that would be illegal in split mode (R4)
        set_cfg(1'b0, rand_map(H + 3));
        burst(40);

        // split mode, every legal fault count (R2, R5, R6)
        for (int k = 0; k <= H; k++) begin
            set_cfg(1'b1, rand_map(k));
            burst(25);
        end

        // broken wires crowded at either end
        set_cfg(1'b1, {{H{1'b0}}, {H{1'b1}}});
        step(1'b1, '1, 1'b1);
        step(1'b1, 16'hA5C3, 1'b1);
        burst(8);
        set_cfg(1'b1, {{H{1'b1}}, {H{1'b0}}});
        step(1'b1, 16'h5A3C, 1'b1);
        step(1'b1, '0, 1'b1);
        burst(8);

        // R8: flits offered without room never arrive
        set_cfg(1'b1, rand_map(3));
        for (int i = 0; i < 5; i++) step(1'b1, W'($urandom), 1'b0);
        step(1'b0, '0, 1'b1);

        // R7: one wire past the limit shuts the link
        set_cfg(1'b1, rand_map(H + 1));
        for (int i = 0; i < 8; i++) step(1'b1, W'($urandom), 1'b1);
        set_cfg(1'b0, fault_map);
        burst(10);
        step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule